// File: doc/BRIEF.md
# DDR3 Power-Down Entry/Exit Sequencer

This block sits on the controller side of a DDR3 interface. It moves the device into power-down and brings it back out. While doing so it enforces the clock-enable timing rules. A scheduler asks for entry or exit, and it reports whether any bank is open at the moment of entry. The sequencer drives the clock-enable output and owns the command slot. It forces a no-operation command whenever a real command is not yet legal, and passes the scheduler's command through otherwise. All timing values are parameters counted in clock cycles.

The exit type is chosen at entry and held until the next entry. A power-down with a bank open always uses fast exit, with the delay-locked loop kept running. A power-down with every bank precharged uses fast or slow exit, depending on a mode input that mirrors the device's mode-register setting. After a slow exit, ordinary commands become legal before the commands that need the loop locked. The block also does the following:
- It forces an exit when a power-down has lasted as long as its ceiling.
- It keeps the longer gap when a refresh is placed between two power-downs.
- It falls back to its reset state when the device reset is pulled during power-down.

The finite-state machine has three states:
- `ST_RESET`: clock enable low, no commands.
- `ST_AWAKE`: clock enable high.
- `ST_DOWN`: clock enable low, in power-down.

It has four transitions:
- RELEASE: `ST_RESET`→`ST_AWAKE` when `dev_rst_n` is high.
- ENTER: `ST_AWAKE`→`ST_DOWN` on an accepted `enter_req`.
- LEAVE: `ST_DOWN`→`ST_AWAKE` on an accepted `exit_req` or on the forced exit at the ceiling.
- DEVRST: any state→`ST_RESET` while `dev_rst_n` is low.

Top module: `ddr3_pd_seq`

## Requirements
- R1: While `rst_n` or `dev_rst_n` is low, and in the cycle after `rst_n` rises while `dev_rst_n` is still low, the outputs are as follows: `cke`=0, `in_pd`=0, `cmd_ok`=0, `dll_cmd_ok`=0, `ref_ok`=0, and `cmd_out`=NOP. The command code is {cs_n,ras_n,cas_n,we_n} and NOP is 4'b0111.
- R2: An `enter_req` accepted in `ST_AWAKE` takes effect in the next cycle. In that cycle `cke`=0 and `in_pd`=1, and both `cmd_ok` and `dll_cmd_ok` are 0.
- R3: An exit is taken only after `cke` has been low for at least T_CKE cycles. While an `exit_req` is being refused, `busy` is 1.
- R4: An entry is taken only after `cke` has been high for at least T_CKE cycles. While an `enter_req` is being refused, `busy` is 1.
- R5: An accepted exit raises `cke` in the next cycle, and `in_pd` drops in that same cycle. Counting that cycle as cycle 1, `cmd_ok` is 0 up to cycle T_XP and becomes 1 in cycle T_XP+1.
- R6: If `bank_open`=1 or `fast_exit_mode`=1 at entry, the exit is fast and `dll_cmd_ok` rises together with `cmd_ok`. Otherwise the exit is slow and `dll_cmd_ok` is 0 up to cycle T_XPDLL, becoming 1 in cycle T_XPDLL+1. The values used are the ones sampled at entry.
- R7: A power-down whose `cke`-low run reaches 9×T_REFI cycles is ended by the block in the next cycle without any `exit_req`.
- R8: `ref_ok` becomes 1 in cycle T_XPDLL+1 after an exit. If `ref_issue` was pulsed since the exit, an entry also waits until `cke` has been high for T_XPDLL cycles, and `busy` shows the refusal.
- R9: When `dev_rst_n` goes low during power-down, the block is in `ST_RESET` in the next cycle, with `in_pd`=0 and `cke`=0. When `dev_rst_n` returns high, `cke` rises in the next cycle and the latencies follow the slow-exit rule.
- R10: `cmd_out` equals `cmd_in` only while `cmd_ok`=1. Otherwise it is NOP, whatever `cmd_in`, `enter_req` or `exit_req` carry, so it is NOP in every power-down cycle and in the first cycle with `cke` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| dev_rst_n | input | 1 | Device reset level, active low |
| enter_req | input | 1 | Request to enter power-down |
| exit_req | input | 1 | Request to leave power-down |
| bank_open | input | 1 | At least one bank is open |
| fast_exit_mode | input | 1 | Precharged power-down keeps the delay-locked loop running |
| ref_issue | input | 1 | Pulse: a refresh was issued while awake |
| cmd_in | input | 4 | Scheduler command {cs_n,ras_n,cas_n,we_n} |
| cke | output | 1 | Clock enable to the device |
| cmd_out | output | 4 | Command slot to the device |
| cmd_ok | output | 1 | Ordinary commands may be issued |
| dll_cmd_ok | output | 1 | Commands needing a locked loop may be issued |
| ref_ok | output | 1 | A refresh may be issued |
| busy | output | 1 | A pending request is being held off by a minimum timer |
| in_pd | output | 1 | Device is in power-down |

## Verification
The state, `cke` and `in_pd` are registered, so each takes its new value one cycle after the request is sampled. In the cycle after an exit, `cmd_ok` is due T_XP cycles later and `dll_cmd_ok` and `ref_ok` are due T_XPDLL cycles later. `busy` and `cmd_out` are combinational and follow the inputs of the same cycle. Each stimulus task files its expected values with the absolute cycle at which they are due, counted from the edge at which the request is sampled. The monitor compares them in that cycle, a short delay after the falling edge, once the driver's inputs for the cycle have settled. Each latency is checked on both sides, the last cycle at the old value and the first at the new, so a one-cycle shift is caught.

// File: rtl/ddr3_pd_pkg.sv
package ddr3_pd_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_AWAKE = 2'd1,
        ST_DOWN  = 2'd2
    } pd_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;

endpackage

// File: rtl/ddr3_pd_cnt.sv
module ddr3_pd_cnt #(
    parameter int W   = 8,
    parameter int MAX = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAX_V = W'(MAX);

    // clr loads 1 so the first cycle of a new run reads 1; counting saturates at MAX
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= W'(1);
        else if (en && cnt != MAX_V)
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/ddr3_pd_gate.sv
module ddr3_pd_gate #(
    parameter int W       = 4,
    parameter int T_XP    = 3,
    parameter int T_XPDLL = 10
) (
    input  logic         awake,
    input  logic         slow,
    input  logic [W-1:0] up_cnt,
    output logic         cmd_ok,
    output logic         dll_cmd_ok,
    output logic         ref_ok
);

    localparam logic [W-1:0] XP_V    = W'(T_XP);
    localparam logic [W-1:0] XPDLL_V = W'(T_XPDLL);

    logic xp_done;
    logic xpdll_done;

    assign xp_done    = awake && (up_cnt > XP_V);
    assign xpdll_done = awake && (up_cnt > XPDLL_V);

    always_comb begin
        cmd_ok     = xp_done;
        dll_cmd_ok = slow ? xpdll_done : xp_done;
        ref_ok     = xpdll_done;
    end

endmodule

// File: rtl/ddr3_pd_seq.sv
module ddr3_pd_seq
    import ddr3_pd_pkg::*;
#(
    parameter int T_CKE   = 3,
    parameter int T_XP    = 3,
    parameter int T_XPDLL = 10,
    parameter int T_REFI  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_rst_n,
    input  logic       enter_req,
    input  logic       exit_req,
    input  logic       bank_open,
    input  logic       fast_exit_mode,
    input  logic       ref_issue,
    input  logic [3:0] cmd_in,
    output logic       cke,
    output logic [3:0] cmd_out,
    output logic       cmd_ok,
    output logic       dll_cmd_ok,
    output logic       ref_ok,
    output logic       busy,
    output logic       in_pd
);

    localparam int T_PD_MAX = 9 * T_REFI;
    localparam int PD_W     = $clog2(T_PD_MAX + 1);
    localparam int UP_LIM0  = (T_XPDLL > T_XP) ? T_XPDLL : T_XP;
    localparam int UP_MAX   = ((UP_LIM0 > T_CKE) ? UP_LIM0 : T_CKE) + 1;
    localparam int UP_W     = $clog2(UP_MAX + 1);

    localparam logic [UP_W-1:0] UP_CKE   = UP_W'(T_CKE);
    localparam logic [UP_W-1:0] UP_XPDLL = UP_W'(T_XPDLL);
    localparam logic [PD_W-1:0] PD_CKE   = PD_W'(T_CKE);
    localparam logic [PD_W-1:0] PD_LIMIT = PD_W'(T_PD_MAX);

    pd_state_e        state_q, state_d;
    logic             cke_q;
    logic             slow_q;
    logic             ref_seen_q;
    logic [UP_W-1:0]  up_cnt;
    logic [PD_W-1:0]  pd_cnt;
    logic             entry_ok, exit_ok, force_exit;
    logic             go_awake, go_down;

    assign entry_ok   = (up_cnt >= UP_CKE) && (!ref_seen_q || up_cnt >= UP_XPDLL);
    assign exit_ok    = (pd_cnt >= PD_CKE);
    assign force_exit = (pd_cnt >= PD_LIMIT);
    assign go_awake   = (state_d == ST_AWAKE) && (state_q != ST_AWAKE);
    assign go_down    = (state_d == ST_DOWN)  && (state_q != ST_DOWN);

    // next state: RELEASE, ENTER, LEAVE, DEVRST
    always_comb begin
        state_d = state_q;
        if (!dev_rst_n) begin
            state_d = ST_RESET;                          // DEVRST
        end else begin
            unique case (state_q)
                ST_RESET: state_d = ST_AWAKE;            // RELEASE
                ST_AWAKE: if (enter_req && entry_ok)
                              state_d = ST_DOWN;         // ENTER
                ST_DOWN:  if (force_exit || (exit_req && exit_ok))
                              state_d = ST_AWAKE;        // LEAVE
                default:  state_d = ST_RESET;
            endcase
        end
    end

    // state register and the flags captured on transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RESET;
            cke_q      <= 1'b0;
            slow_q     <= 1'b1;
            ref_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cke_q   <= (state_d == ST_AWAKE);
            if (state_q == ST_RESET && state_d == ST_AWAKE)
                slow_q <= 1'b1;
            else if (go_down)
                slow_q <= !bank_open && !fast_exit_mode;
            if (state_d != ST_AWAKE)
                ref_seen_q <= 1'b0;
            else if (state_q == ST_AWAKE && ref_issue)
                ref_seen_q <= 1'b1;
        end
    end

    ddr3_pd_cnt #(.W(UP_W), .MAX(UP_MAX)) u_up_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go_awake),
        .en    (state_q == ST_AWAKE),
        .cnt   (up_cnt)
    );

    ddr3_pd_cnt #(.W(PD_W), .MAX(T_PD_MAX)) u_pd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go_down),
        .en    (state_q == ST_DOWN),
        .cnt   (pd_cnt)
    );

    ddr3_pd_gate #(.W(UP_W), .T_XP(T_XP), .T_XPDLL(T_XPDLL)) u_gate (
        .awake      (state_q == ST_AWAKE),
        .slow       (slow_q),
        .up_cnt     (up_cnt),
        .cmd_ok     (cmd_ok),
        .dll_cmd_ok (dll_cmd_ok),
        .ref_ok     (ref_ok)
    );

    // outputs
    always_comb begin
        cke     = cke_q;
        in_pd   = (state_q == ST_DOWN);
        cmd_out = cmd_ok ? cmd_in : CMD_NOP;
        busy    = ((state_q == ST_AWAKE) && enter_req && !entry_ok) ||
                  ((state_q == ST_DOWN)  && exit_req  && !exit_ok && !force_exit);
    end

endmodule

// File: rtl/ddr3_pd_seq_chk.sv
module ddr3_pd_seq_chk
    import ddr3_pd_pkg::*;
#(
    parameter int T_CKE  = 3,
    parameter int T_REFI = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       in_pd,
    input logic       cmd_ok,
    input logic       dll_cmd_ok,
    input logic       ref_ok,
    input logic [3:0] cmd_out
);

    localparam int T_PD_MAX = 9 * T_REFI;
    localparam int LEN_W    = $clog2(T_PD_MAX + 2);

    logic [LEN_W-1:0] pd_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pd_len <= '0;
        else if (in_pd)
            pd_len <= pd_len + LEN_W'(1);
        else
            pd_len <= '0;
    end

    assert_pd_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_pd |-> !cke);

    assert_entry_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_pd) |-> (!cmd_ok && !dll_cmd_ok));

    assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_pd) && cke) |-> (pd_len >= LEN_W'(T_CKE)));

    assert_exit_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_pd) && cke) |-> (!cmd_ok && cmd_out == CMD_NOP));

    assert_dll_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dll_cmd_ok |-> cmd_ok);

    assert_pd_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_pd |-> (pd_len < LEN_W'(T_PD_MAX)));

    assert_ref_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ok |-> cmd_ok);

    assert_pd_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_pd |-> (cmd_out == CMD_NOP));

endmodule

bind ddr3_pd_seq ddr3_pd_seq_chk #(.T_CKE(T_CKE), .T_REFI(T_REFI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .in_pd      (in_pd),
    .cmd_ok     (cmd_ok),
    .dll_cmd_ok (dll_cmd_ok),
    .ref_ok     (ref_ok),
    .cmd_out    (cmd_out)
);

// File: tb/ddr3_pd_seq_test.sv
module ddr3_pd_seq_test;

    localparam int T_CKE    = 3;
    localparam int T_XP     = 3;
    localparam int T_XPDLL  = 10;
    localparam int T_REFI   = 20;
    localparam int T_PD_MAX = 9 * T_REFI;
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] CMDV = 4'b0001;

    localparam int S_CKE = 0, S_CMDOK = 1, S_DLL = 2, S_REF = 3,
                   S_BUSY = 4, S_INPD = 5, S_CMD = 6;

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, dev_rst_n, enter_req, exit_req, bank_open, fast_exit_mode, ref_issue;
    logic [3:0] cmd_in;
    logic cke, cmd_ok, dll_cmd_ok, ref_ok, busy, in_pd;
    logic [3:0] cmd_out;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    ddr3_pd_seq #(.T_CKE(T_CKE), .T_XP(T_XP), .T_XPDLL(T_XPDLL), .T_REFI(T_REFI)) uut (
        .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .enter_req(enter_req),
        .exit_req(exit_req), .bank_open(bank_open), .fast_exit_mode(fast_exit_mode),
        .ref_issue(ref_issue), .cmd_in(cmd_in), .cke(cke), .cmd_out(cmd_out),
        .cmd_ok(cmd_ok), .dll_cmd_ok(dll_cmd_ok), .ref_ok(ref_ok), .busy(busy),
        .in_pd(in_pd)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int dly, input int sig, input int val, input string tag);
        exp_t e;
        e.cyc = cyc + dly;
        e.sig = sig;
        e.val = val;
        e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic int sample(input int sig);
        case (sig)
            S_CKE:   return int'(cke);
            S_CMDOK: return int'(cmd_ok);
            S_DLL:   return int'(dll_cmd_ok);
            S_REF:   return int'(ref_ok);
            S_BUSY:  return int'(busy);
            S_INPD:  return int'(in_pd);
            default: return int'(cmd_out);
        endcase
    endfunction

    // monitor: pops every expectation due in this cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    int act;
                    act = sample(sb[i].sig);
                    n_checks++;
                    if (act != sb[i].val) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                                 sb[i].tag, cyc, sb[i].sig, act, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        @(posedge clk);
        while (!done && cyc < 5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic enter_pd(input logic bo, input logic fm);
        bank_open = bo;
        fast_exit_mode = fm;
        enter_req = 1'b1;
        push(1, S_INPD, 1, "R2");
        push(1, S_CKE, 0, "R2");
        push(1, S_CMDOK, 0, "R2");
        push(1, S_DLL, 0, "R2");
        push(1, S_CMD, int'(NOP), "R10");
        @(negedge clk);
        enter_req = 1'b0;
    endtask

    task automatic exit_pd(input bit slow);
        exit_req = 1'b1;
        push(1, S_INPD, 0, "R5");
        push(1, S_CKE, 1, "R5");
        push(1, S_CMD, int'(NOP), "R10");
        push(T_XP, S_CMDOK, 0, "R5");
        push(T_XP + 1, S_CMDOK, 1, "R5");
        push(T_XP + 1, S_CMD, int'(CMDV), "R10");
        if (slow) begin
            push(T_XP + 1, S_DLL, 0, "R6");
            push(T_XPDLL, S_DLL, 0, "R6");
            push(T_XPDLL + 1, S_DLL, 1, "R6");
        end else begin
            push(T_XP, S_DLL, 0, "R6");
            push(T_XP + 1, S_DLL, 1, "R6");
        end
        push(T_XPDLL, S_REF, 0, "R8");
        push(T_XPDLL + 1, S_REF, 1, "R8");
        @(negedge clk);
        exit_req = 1'b0;
        repeat (T_XPDLL + 1) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; dev_rst_n = 1'b0; enter_req = 1'b0; exit_req = 1'b0;
        bank_open = 1'b0; fast_exit_mode = 1'b0; ref_issue = 1'b0; cmd_in = CMDV;
        repeat (3) @(negedge clk);

        // R1: reset state held while the device reset is low
        rst_n = 1'b1;
        push(1, S_CKE, 0, "R1");
        push(1, S_INPD, 0, "R1");
        push(1, S_CMDOK, 0, "R1");
        push(1, S_DLL, 0, "R1");
        push(1, S_REF, 0, "R1");
        push(1, S_CMD, int'(NOP), "R1");
        push(2, S_CKE, 0, "R1");
        repeat (2) @(negedge clk);

        // R9: leaving reset follows the slow rule
        dev_rst_n = 1'b1;
        push(1, S_CKE, 1, "R9");
        push(T_XP, S_CMDOK, 0, "R9");
        push(T_XP + 1, S_CMDOK, 1, "R9");
        push(T_XPDLL, S_DLL, 0, "R9");
        push(T_XPDLL + 1, S_DLL, 1, "R9");
        repeat (T_XPDLL + 2) @(negedge clk);

        // R6: active power-down is fast even with the slow mode selected
        enter_pd(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        exit_pd(1'b0);

        // R6: precharged, fast mode
        enter_pd(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        exit_pd(1'b0);

        // R6: precharged, slow mode; bank_open changes during power-down are ignored
        enter_pd(1'b0, 1'b0);
        bank_open = 1'b1;
        repeat (4) @(negedge clk);
        exit_pd(1'b1);

        // R3: early exit request is held off
        enter_pd(1'b1, 1'b0);
        exit_req = 1'b1;
        push(1, S_BUSY, 1, "R3");
        push(2, S_BUSY, 0, "R3");
        push(2, S_INPD, 1, "R3");
        push(2, S_CKE, 0, "R3");
        push(3, S_INPD, 0, "R3");
        repeat (3) @(negedge clk);

        // R4: early entry request is held off
        exit_req = 1'b0;
        enter_req = 1'b1;
        push(1, S_BUSY, 1, "R4");
        push(1, S_INPD, 0, "R4");
        push(2, S_BUSY, 0, "R4");
        push(2, S_CKE, 1, "R4");
        push(3, S_INPD, 1, "R4");
        push(3, S_CKE, 0, "R4");
        repeat (3) @(negedge clk);
        enter_req = 1'b0;

        // R7: forced exit at the ceiling
        push(T_PD_MAX - 1, S_INPD, 1, "R7");
        push(T_PD_MAX - 1, S_CKE, 0, "R7");
        push(T_PD_MAX, S_INPD, 0, "R7");
        push(T_PD_MAX, S_CKE, 1, "R7");
        repeat (T_PD_MAX + T_XPDLL + 2) @(negedge clk);

        // R8: refresh between power-downs stretches the entry gap
        enter_pd(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        exit_req = 1'b1;
        push(6, S_BUSY, 1, "R8");
        push(10, S_BUSY, 0, "R8");
        push(10, S_INPD, 0, "R8");
        push(11, S_INPD, 1, "R8");
        @(negedge clk);
        exit_req = 1'b0;
        ref_issue = 1'b1;
        @(negedge clk);
        ref_issue = 1'b0;
        enter_req = 1'b1;
        repeat (9) @(negedge clk);
        enter_req = 1'b0;

        // R9: device reset during power-down
        repeat (2) @(negedge clk);
        dev_rst_n = 1'b0;
        push(1, S_INPD, 0, "R9");
        push(1, S_CKE, 0, "R9");
        push(1, S_CMDOK, 0, "R9");
        @(negedge clk);
        dev_rst_n = 1'b1;
        push(1, S_CKE, 1, "R9");
        push(T_XPDLL, S_DLL, 0, "R9");
        push(T_XPDLL + 1, S_DLL, 1, "R9");
        repeat (T_XPDLL + 3) @(negedge clk);

        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule